// File: doc/BRIEF.md
# Dual-Mode Translation Lookaside Buffer with Side-Effect Invalidation

This block keeps recently completed address translations in two separate direct-indexed buffers: one serves user-mode lookups and the other serves supervisor-mode lookups. A lookup gives a virtual address and a mode. One cycle later the block returns a registered result: a hit flag, the physical frame number, and the read-only and cache-inhibit flags. After a miss, the page walker writes the translation into the buffer for the matching mode through a fill port. When the mapping-enable input for the requested mode is low, the address is not translated. The frame number is then the virtual page number itself.

Software never clears entries directly. Entries are invalidated as a side effect of ordinary register accesses. Accesses to the buffer control register and to the two root table pointer registers flush one buffer or both. A data write tagged with the purge function code removes the entry for that one virtual address from both buffers. A whole-buffer flush clears every valid bit in one cycle.

Top module: `dual_tlb`

## Requirements
- R1: After reset, `lk_valid_o` and `lk_hit_o` are 0, and every lookup in either mode misses until a fill has been made.
- R2: A lookup requested in cycle t gives `lk_valid_o`=1 in cycle t+1. A lookup that hits returns the frame number and the read-only and cache-inhibit flags that were filled. `lk_valid_o` is 0 in the cycle after any cycle with no request.
- R3: The user buffer and the supervisor buffer are independent. A fill with `fill_super_i`=0 is never seen by a lookup with `lk_super_i`=1, and a fill with `fill_super_i`=1 is never seen by a lookup with `lk_super_i`=0.
- R4: The entry index is va[IDX_W+11:12], and the stored tag is va[31:IDX_W+12]. A fill to an occupied index replaces the old entry. A lookup hits only when its tag matches the stored tag.
- R5: A 32-bit read (`reg_long_i`=1, `reg_we_i`=0) of the control register (`reg_sel_i`=2) invalidates both buffers. A 16-bit read of that register has no effect.
- R6: A 32-bit write of 0 to the control register invalidates only the user buffer. A 32-bit write of 0x8000 invalidates only the supervisor buffer. Any other value, and any 16-bit write, has no effect.
- R7: A write of any width to the user root pointer (`reg_sel_i`=1) invalidates the user buffer. A write to the supervisor root pointer (`reg_sel_i`=0) invalidates the supervisor buffer.
- R8: A bus write with function code 3 removes the entry for that virtual address from both buffers. An entry at the same index with a different tag is kept. Writes with any other function code do not purge.
- R9: When the mapping-enable input for the requested mode is 0, the result has hit=1, bypass=1, a frame number equal to va[31:12], and ro=ci=0. The other mode is not affected.
- R10: A flush has priority over a fill to the same buffer in the same cycle. The filled entry is not valid afterwards.
- R11: A lookup in the same cycle as a fill to the same entry sees the contents from before the fill. The next lookup sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_en_user_i | input | 1 | Enables translation for user mode |
| map_en_sup_i | input | 1 | Enables translation for supervisor mode |
| lk_req_i | input | 1 | Lookup request |
| lk_super_i | input | 1 | Lookup mode, 1 = supervisor |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_valid_o | output | 1 | Result valid, one cycle after the request |
| lk_hit_o | output | 1 | Translation available |
| lk_bypass_o | output | 1 | Untranslated pass-through result |
| lk_pfn_o | output | 20 | Physical frame number |
| lk_ro_o | output | 1 | Page is read-only |
| lk_ci_o | output | 1 | Page is cache-inhibited |
| fill_i | input | 1 | Fill strobe from the walker |
| fill_super_i | input | 1 | Mode of the buffer to fill |
| fill_va_i | input | 32 | Virtual address of the fill |
| fill_pfn_i | input | 20 | Frame number to store |
| fill_ro_i | input | 1 | Read-only flag to store |
| fill_ci_i | input | 1 | Cache-inhibit flag to store |
| reg_stb_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register access is a write |
| reg_long_i | input | 1 | Access is 32 bits wide (0 = 16 bits) |
| reg_sel_i | input | 2 | 0 supervisor root, 1 user root, 2 control, 3 none |
| reg_wdata_i | input | 32 | Register write data |
| bus_stb_i | input | 1 | Data bus access strobe |
| bus_we_i | input | 1 | Data bus access is a write |
| bus_fc_i | input | 3 | Function code of the bus access |
| bus_va_i | input | 32 | Virtual address of the bus access |

## Verification
The bench builds the block with IDX_W=4, so each buffer has 16 entries. This puts the index in va[15:12] and the tag in va[31:16]. With so few entries, the bench can easily make two addresses that share an index but have different tags. It uses these to test replacement and purges that must not hit the neighbouring entry. The bench also drives a fill at the same time as a flush or a lookup, to check the same-cycle ordering rules.

// File: rtl/dual_tlb_pkg.sv
package dual_tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PAGE_W = 12;
  localparam int PFN_W  = VA_W - PAGE_W;

  typedef enum logic [1:0] {
    SEL_SUP_ROOT = 2'd0,
    SEL_USR_ROOT = 2'd1,
    SEL_TLB_CTL  = 2'd2,
    SEL_NONE     = 2'd3
  } reg_sel_e;

  localparam logic [31:0] CTL_USR_CODE = 32'h0000_0000;
  localparam logic [31:0] CTL_SUP_CODE = 32'h0000_8000;
  localparam logic [2:0]  FC_PURGE     = 3'd3;
  localparam int          MODE_USR     = 0;
  localparam int          MODE_SUP     = 1;
endpackage

// File: rtl/tlb_inval_dec.sv
module tlb_inval_dec
  import dual_tlb_pkg::*;
(
  input  logic        reg_stb_i,
  input  logic        reg_we_i,
  input  logic        reg_long_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic        bus_stb_i,
  input  logic        bus_we_i,
  input  logic [2:0]  bus_fc_i,
  output logic [1:0]  flush_o,
  output logic        purge_o
);
  logic ctl_rd_all, ctl_wr_usr, ctl_wr_sup, root_wr_usr, root_wr_sup;

  always_comb begin
    ctl_rd_all  = reg_stb_i && !reg_we_i && reg_long_i && (reg_sel_i == SEL_TLB_CTL);
    ctl_wr_usr  = reg_stb_i && reg_we_i && reg_long_i && (reg_sel_i == SEL_TLB_CTL)
                  && (reg_wdata_i == CTL_USR_CODE);
    ctl_wr_sup  = reg_stb_i && reg_we_i && reg_long_i && (reg_sel_i == SEL_TLB_CTL)
                  && (reg_wdata_i == CTL_SUP_CODE);
    root_wr_usr = reg_stb_i && reg_we_i && (reg_sel_i == SEL_USR_ROOT);
    root_wr_sup = reg_stb_i && reg_we_i && (reg_sel_i == SEL_SUP_ROOT);
    flush_o[MODE_USR] = ctl_rd_all || ctl_wr_usr || root_wr_usr;
    flush_o[MODE_SUP] = ctl_rd_all || ctl_wr_sup || root_wr_sup;
    purge_o = bus_stb_i && bus_we_i && (bus_fc_i == FC_PURGE);
  end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
  import dual_tlb_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int TAG_W = VA_W - PAGE_W - IDX_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             purge_i,
  input  logic [IDX_W-1:0] purge_idx_i,
  input  logic [TAG_W-1:0] purge_tag_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_ro_i,
  input  logic             fill_ci_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             rd_hit_o,
  output logic [PFN_W-1:0] rd_pfn_o,
  output logic             rd_ro_o,
  output logic             rd_ci_o
);
  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PFN_W-1:0] pfn_q [DEPTH];
  logic [DEPTH-1:0] ro_q, ci_q;
  logic             purge_match;

  assign purge_match = vld_q[purge_idx_i] && (tag_q[purge_idx_i] == purge_tag_i);

  // flush beats fill; purge beats fill on the same index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else begin
      if (fill_i) vld_q[fill_idx_i] <= 1'b1;
      if (purge_i && purge_match) vld_q[purge_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[fill_idx_i] <= fill_tag_i;
      pfn_q[fill_idx_i] <= fill_pfn_i;
      ro_q[fill_idx_i]  <= fill_ro_i;
      ci_q[fill_idx_i]  <= fill_ci_i;
    end
  end

  always_comb begin
    rd_hit_o = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
    rd_pfn_o = pfn_q[rd_idx_i];
    rd_ro_o  = ro_q[rd_idx_i];
    rd_ci_o  = ci_q[rd_idx_i];
  end
endmodule

// File: rtl/dual_tlb.sv
module dual_tlb
  import dual_tlb_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             map_en_user_i,
  input  logic             map_en_sup_i,
  input  logic             lk_req_i,
  input  logic             lk_super_i,
  input  logic [31:0]      lk_va_i,
  output logic             lk_valid_o,
  output logic             lk_hit_o,
  output logic             lk_bypass_o,
  output logic [19:0]      lk_pfn_o,
  output logic             lk_ro_o,
  output logic             lk_ci_o,
  input  logic             fill_i,
  input  logic             fill_super_i,
  input  logic [31:0]      fill_va_i,
  input  logic [19:0]      fill_pfn_i,
  input  logic             fill_ro_i,
  input  logic             fill_ci_i,
  input  logic             reg_stb_i,
  input  logic             reg_we_i,
  input  logic             reg_long_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic             bus_stb_i,
  input  logic             bus_we_i,
  input  logic [2:0]       bus_fc_i,
  input  logic [31:0]      bus_va_i
);
  localparam int TAG_W = VA_W - PAGE_W - IDX_W;
  localparam int IDX_LO = PAGE_W;
  localparam int TAG_LO = PAGE_W + IDX_W;

  logic [1:0]       flush;
  logic             purge;
  logic [1:0]       bank_hit, bank_ro, bank_ci;
  logic [PFN_W-1:0] bank_pfn [2];
  logic             sel_en;

  tlb_inval_dec u_dec (
    .reg_stb_i  (reg_stb_i),
    .reg_we_i   (reg_we_i),
    .reg_long_i (reg_long_i),
    .reg_sel_i  (reg_sel_i),
    .reg_wdata_i(reg_wdata_i),
    .bus_stb_i  (bus_stb_i),
    .bus_we_i   (bus_we_i),
    .bus_fc_i   (bus_fc_i),
    .flush_o    (flush),
    .purge_o    (purge)
  );

  for (genvar m = 0; m < 2; m++) begin : g_bank
    logic fill_this;
    assign fill_this = fill_i && (fill_super_i == (m == MODE_SUP));
    tlb_bank #(.IDX_W(IDX_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush[m]),
      .purge_i    (purge),
      .purge_idx_i(bus_va_i[TAG_LO-1:IDX_LO]),
      .purge_tag_i(bus_va_i[VA_W-1:TAG_LO]),
      .fill_i     (fill_this),
      .fill_idx_i (fill_va_i[TAG_LO-1:IDX_LO]),
      .fill_tag_i (fill_va_i[VA_W-1:TAG_LO]),
      .fill_pfn_i (fill_pfn_i),
      .fill_ro_i  (fill_ro_i),
      .fill_ci_i  (fill_ci_i),
      .rd_idx_i   (lk_va_i[TAG_LO-1:IDX_LO]),
      .rd_tag_i   (lk_va_i[VA_W-1:TAG_LO]),
      .rd_hit_o   (bank_hit[m]),
      .rd_pfn_o   (bank_pfn[m]),
      .rd_ro_o    (bank_ro[m]),
      .rd_ci_o    (bank_ci[m])
    );
  end

  assign sel_en = lk_super_i ? map_en_sup_i : map_en_user_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o  <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_bypass_o <= 1'b0;
      lk_pfn_o    <= '0;
      lk_ro_o     <= 1'b0;
      lk_ci_o     <= 1'b0;
    end else if (!lk_req_i) begin
      lk_valid_o  <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_bypass_o <= 1'b0;
    end else if (!sel_en) begin
      lk_valid_o  <= 1'b1;
      lk_hit_o    <= 1'b1;
      lk_bypass_o <= 1'b1;
      lk_pfn_o    <= lk_va_i[VA_W-1:PAGE_W];
      lk_ro_o     <= 1'b0;
      lk_ci_o     <= 1'b0;
    end else begin
      lk_valid_o  <= 1'b1;
      lk_hit_o    <= bank_hit[lk_super_i];
      lk_bypass_o <= 1'b0;
      lk_pfn_o    <= bank_pfn[lk_super_i];
      lk_ro_o     <= bank_ro[lk_super_i];
      lk_ci_o     <= bank_ci[lk_super_i];
    end
  end
endmodule

// File: rtl/dual_tlb_chk.sv
module dual_tlb_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        map_en_user_i,
  input logic        map_en_sup_i,
  input logic        lk_req_i,
  input logic        lk_super_i,
  input logic [31:0] lk_va_i,
  input logic        lk_valid_o,
  input logic        lk_hit_o,
  input logic        lk_bypass_o,
  input logic [19:0] lk_pfn_o,
  input logic        lk_ro_o,
  input logic        lk_ci_o,
  input logic        reg_stb_i,
  input logic        reg_we_i,
  input logic        reg_long_i,
  input logic [1:0]  reg_sel_i,
  input logic [31:0] reg_wdata_i
);
  logic en_now, rd_all, wr_usr;
  assign en_now = lk_super_i ? map_en_sup_i : map_en_user_i;
  assign rd_all = reg_stb_i && !reg_we_i && reg_long_i && (reg_sel_i == 2'd2);
  assign wr_usr = reg_stb_i && reg_we_i && (reg_sel_i == 2'd1);

  assert_valid_on_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_valid_o);
  assert_idle_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> (!lk_valid_o && !lk_hit_o));
  assert_bypass_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && !en_now) |=> (lk_hit_o && lk_bypass_o && !lk_ro_o && !lk_ci_o
                               && lk_pfn_o == $past(lk_va_i[31:12])));
  assert_flush_all_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_all) && lk_req_i && en_now) |=> !lk_hit_o);
  assert_root_user_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_usr) && lk_req_i && !lk_super_i && map_en_user_i) |=> !lk_hit_o);
endmodule

bind dual_tlb dual_tlb_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .map_en_user_i(map_en_user_i),
  .map_en_sup_i (map_en_sup_i),
  .lk_req_i     (lk_req_i),
  .lk_super_i   (lk_super_i),
  .lk_va_i      (lk_va_i),
  .lk_valid_o   (lk_valid_o),
  .lk_hit_o     (lk_hit_o),
  .lk_bypass_o  (lk_bypass_o),
  .lk_pfn_o     (lk_pfn_o),
  .lk_ro_o      (lk_ro_o),
  .lk_ci_o      (lk_ci_o),
  .reg_stb_i    (reg_stb_i),
  .reg_we_i     (reg_we_i),
  .reg_long_i   (reg_long_i),
  .reg_sel_i    (reg_sel_i),
  .reg_wdata_i  (reg_wdata_i)
);

// File: tb/dual_tlb_tb_top.sv
`timescale 1ns/1ps
module dual_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_en_user = 1'b1, map_en_sup = 1'b1;
  logic        lk_req = 1'b0, lk_super = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_valid, lk_hit, lk_bypass, lk_ro, lk_ci;
  logic [19:0] lk_pfn;
  logic        fill = 1'b0, fill_super = 1'b0, fill_ro = 1'b0, fill_ci = 1'b0;
  logic [31:0] fill_va = '0;
  logic [19:0] fill_pfn = '0;
  logic        reg_stb = 1'b0, reg_we = 1'b0, reg_long = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [31:0] reg_wdata = '0;
  logic        bus_stb = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_fc = '0;
  logic [31:0] bus_va = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_tlb #(.IDX_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .map_en_user_i(map_en_user), .map_en_sup_i(map_en_sup),
    .lk_req_i(lk_req), .lk_super_i(lk_super), .lk_va_i(lk_va),
    .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_bypass_o(lk_bypass),
    .lk_pfn_o(lk_pfn), .lk_ro_o(lk_ro), .lk_ci_o(lk_ci),
    .fill_i(fill), .fill_super_i(fill_super), .fill_va_i(fill_va),
    .fill_pfn_i(fill_pfn), .fill_ro_i(fill_ro), .fill_ci_i(fill_ci),
    .reg_stb_i(reg_stb), .reg_we_i(reg_we), .reg_long_i(reg_long),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .bus_stb_i(bus_stb), .bus_we_i(bus_we), .bus_fc_i(bus_fc), .bus_va_i(bus_va)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // all stimulus tasks start and end at a falling edge
  task automatic set_fill(input logic s, input logic [31:0] va, input logic [19:0] pfn,
                          input logic ro, input logic ci);
    fill = 1'b1; fill_super = s; fill_va = va; fill_pfn = pfn; fill_ro = ro; fill_ci = ci;
  endtask

  task automatic step_clear();
    @(posedge clk); @(negedge clk);
    fill = 1'b0; reg_stb = 1'b0; bus_stb = 1'b0; lk_req = 1'b0;
  endtask

  task automatic do_fill(input logic s, input logic [31:0] va, input logic [19:0] pfn,
                         input logic ro, input logic ci);
    set_fill(s, va, pfn, ro, ci);
    step_clear();
  endtask

  task automatic do_reg(input logic [1:0] sel, input logic we, input logic lng,
                        input logic [31:0] d);
    reg_stb = 1'b1; reg_sel = sel; reg_we = we; reg_long = lng; reg_wdata = d;
    step_clear();
  endtask

  task automatic do_bus(input logic [2:0] fc, input logic [31:0] va);
    bus_stb = 1'b1; bus_we = 1'b1; bus_fc = fc; bus_va = va;
    step_clear();
  endtask

  task automatic look(input logic s, input logic [31:0] va);
    lk_req = 1'b1; lk_super = s; lk_va = va;
    step_clear();
  endtask

  task automatic expect_hit(input string req, input logic s, input logic [31:0] va,
                            input logic exp_hit, input logic [19:0] exp_pfn);
    look(s, va);
    chk(req, "valid", lk_valid, 1);
    chk(req, "hit", lk_hit, exp_hit);
    if (exp_hit) chk(req, "pfn", lk_pfn, exp_pfn);
  endtask

  task automatic fill_both();
    do_fill(0, 32'h1234_5000, 20'hAAAA1, 0, 0);
    do_fill(1, 32'h0000_7000, 20'hBBBB2, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1", "valid after reset", lk_valid, 0);
    chk("R1", "hit after reset", lk_hit, 0);
    expect_hit("R1", 0, 32'h0001_3000, 0, 0);
    expect_hit("R1", 1, 32'h0001_3000, 0, 0);
    @(posedge clk); @(negedge clk);
    chk("R2", "valid drops without request", lk_valid, 0);
  endtask

  task automatic t_fill_hit();
    do_fill(0, 32'h1234_5000, 20'hABCDE, 1, 0);
    expect_hit("R2", 0, 32'h1234_5abc, 1, 20'hABCDE);
    chk("R2", "ro", lk_ro, 1);
    chk("R2", "ci", lk_ci, 0);
    chk("R2", "bypass", lk_bypass, 0);
    do_fill(1, 32'h0000_7000, 20'h11111, 0, 1);
    expect_hit("R2", 1, 32'h0000_7000, 1, 20'h11111);
    chk("R2", "ci", lk_ci, 1);
    chk("R2", "ro", lk_ro, 0);
  endtask

  task automatic t_modes();
    expect_hit("R3", 1, 32'h1234_5000, 0, 0);
    expect_hit("R3", 0, 32'h0000_7000, 0, 0);
  endtask

  task automatic t_conflict();
    do_fill(0, 32'h5678_5000, 20'h22222, 0, 0);
    expect_hit("R4", 0, 32'h1234_5000, 0, 0);
    expect_hit("R4", 0, 32'h5678_5000, 1, 20'h22222);
    expect_hit("R4", 0, 32'h5678_6000, 0, 0);
  endtask

  task automatic t_flush_all();
    fill_both();
    do_reg(2'd2, 0, 0, 0);
    expect_hit("R5", 0, 32'h1234_5000, 1, 20'hAAAA1);
    expect_hit("R5", 1, 32'h0000_7000, 1, 20'hBBBB2);
    do_reg(2'd2, 0, 1, 0);
    expect_hit("R5", 0, 32'h1234_5000, 0, 0);
    expect_hit("R5", 1, 32'h0000_7000, 0, 0);
  endtask

  task automatic t_ctl_write();
    fill_both();
    do_reg(2'd2, 1, 0, 32'h0);
    expect_hit("R6", 0, 32'h1234_5000, 1, 20'hAAAA1);
    do_reg(2'd2, 1, 1, 32'h1234);
    expect_hit("R6", 0, 32'h1234_5000, 1, 20'hAAAA1);
    expect_hit("R6", 1, 32'h0000_7000, 1, 20'hBBBB2);
    do_reg(2'd2, 1, 1, 32'h0);
    expect_hit("R6", 0, 32'h1234_5000, 0, 0);
    expect_hit("R6", 1, 32'h0000_7000, 1, 20'hBBBB2);
    fill_both();
    do_reg(2'd2, 1, 1, 32'h8000);
    expect_hit("R6", 1, 32'h0000_7000, 0, 0);
    expect_hit("R6", 0, 32'h1234_5000, 1, 20'hAAAA1);
  endtask

  task automatic t_root();
    fill_both();
    do_reg(2'd1, 1, 0, 32'h00055);
    expect_hit("R7", 0, 32'h1234_5000, 0, 0);
    expect_hit("R7", 1, 32'h0000_7000, 1, 20'hBBBB2);
    fill_both();
    do_reg(2'd0, 1, 1, 32'h00066);
    expect_hit("R7", 1, 32'h0000_7000, 0, 0);
    expect_hit("R7", 0, 32'h1234_5000, 1, 20'hAAAA1);
  endtask

  task automatic t_purge();
    do_fill(0, 32'h1234_5000, 20'h0C0C0, 0, 0);
    do_fill(1, 32'h1234_5000, 20'h0D0D0, 0, 0);
    do_fill(0, 32'h0000_3000, 20'h0E0E0, 0, 0);
    do_bus(3'd1, 32'h1234_5000);
    expect_hit("R8", 0, 32'h1234_5000, 1, 20'h0C0C0);
    do_bus(3'd3, 32'h9999_5000);
    expect_hit("R8", 1, 32'h1234_5000, 1, 20'h0D0D0);
    do_bus(3'd3, 32'h1234_5004);
    expect_hit("R8", 0, 32'h1234_5000, 0, 0);
    expect_hit("R8", 1, 32'h1234_5000, 0, 0);
    expect_hit("R8", 0, 32'h0000_3000, 1, 20'h0E0E0);
  endtask

  task automatic t_bypass();
    do_fill(1, 32'h0000_7000, 20'h31313, 1, 1);
    map_en_user = 1'b0;
    expect_hit("R9", 0, 32'h1234_5678, 1, 20'h12345);
    chk("R9", "bypass", lk_bypass, 1);
    chk("R9", "ro", lk_ro, 0);
    chk("R9", "ci", lk_ci, 0);
    expect_hit("R9", 1, 32'h0000_7000, 1, 20'h31313);
    chk("R9", "other mode bypass", lk_bypass, 0);
    map_en_user = 1'b1;
  endtask

  task automatic t_fill_vs_flush();
    set_fill(0, 32'h4444_9000, 20'h44444, 0, 0);
    reg_stb = 1'b1; reg_sel = 2'd2; reg_we = 1'b0; reg_long = 1'b1;
    step_clear();
    expect_hit("R10", 0, 32'h4444_9000, 0, 0);
  endtask

  task automatic t_same_cycle();
    set_fill(1, 32'h7777_a000, 20'h77777, 0, 0);
    lk_req = 1'b1; lk_super = 1'b1; lk_va = 32'h7777_a000;
    step_clear();
    chk("R11", "hit with concurrent fill", lk_hit, 0);
    expect_hit("R11", 1, 32'h7777_a000, 1, 20'h77777);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_hit();
    t_modes();
    t_conflict();
    t_flush_all();
    t_ctl_write();
    t_root();
    t_purge();
    t_bypass();
    t_fill_vs_flush();
    t_same_cycle();
    summary();
  end
endmodule